// File: doc/BRIEF.md
# ADC Conversion Trigger and Accumulation Sequencer

This block is the digital control that sits in front of an abstract analog-to-digital converter. Software programs it through a small register write port. It holds a command register, a positive-input select, a negative-input select and a sample-count exponent. The command register picks the trigger source, the conversion mode and single-ended or differential operation. When a trigger arrives, the block pulses a request to the converter. It collects each returned result word, accumulates series or burst runs, can scale the sum back to 12-bit magnitude, and publishes the finished value with a one-cycle valid pulse.

The converter is seen only through a request pulse, a done pulse and a 12-bit result word, so the converter's latency can be anything. The register map is as follows:

| Address | Register |
|---|---|
| 0 | Command |
| 1 | Positive select |
| 2 | Negative select |
| 3 | Sample-count exponent |

The sample count is 2 raised to the exponent, from 1 to 64.

Top module: `adc_conv_seq`

## Requirements
- R1: The command register resets to 0x00 and reads back on `cmdState`, with the following fields:
  - bit 7: differential select
  - bits 6:4: mode
  - bits 2:0: start field
  - bit 3: always reads 0
- R2: With bit 7 clear, results are zero-extended to 19 bits. With bit 7 set, they are sign-extended as two's complement. `convDiff` follows bit 7.
- R3: Mode 0 delivers the top 8 bits of each conversion, and mode 1 delivers all 12 bits. In both modes every finished conversion gives one valid result.
- R4: Modes 2 and 3 (series) run one conversion per trigger and add it to the accumulator. `resValid` pulses only after the programmed sample count of conversions.
- R5: Modes 4 and 5 (burst) run the whole sample count of conversions back to back from a single trigger, then deliver the result.
- R6: Modes 3 and 5 shift the sum right by the exponent. The shift is arithmetic when differential and logical otherwise. Modes 2 and 4 deliver the full 19-bit sum.
- R7: A command write that moves from an accumulating mode (2 to 5) to a single mode (0 or 1) discards any partial sum.
- R8: The start field selects the trigger source:
  - 1: the command write itself starts a conversion
  - 2: a write to address 1 starts a conversion
  - 3: a write to address 2 starts a conversion
  - 4: a pulse on `evtTrig` starts a conversion
  - Writes to the other select register do not trigger.
- R9: Writing start value 0 (stop) aborts any conversion or run at once. A late converter done pulse then yields no result.
- R10: Start value 1 returns to 0 when its conversion or run finishes, unless `freeRun` is high. With `freeRun` high, the block restarts the conversion continuously.
- R11: Writing start value 1 while `enable` is low stores 0 instead. No trigger is accepted while `enable` is low.
- R12: A trigger that arrives while `busy` is high is ignored.
- R13: Mode values 6 and 7, and start values 5 to 7, never start a conversion.
- R14: The exponent register accepts values 0 to 6. A write above 6 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable |
| freeRun | input | 1 | Continuous restart of immediate conversions |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| evtTrig | input | 1 | External event trigger pulse |
| convReq | output | 1 | One-cycle conversion request to the converter |
| convDiff | output | 1 | Differential operation for the converter |
| convPos | output | 8 | Positive input select |
| convNeg | output | 8 | Negative input select |
| convDone | input | 1 | Converter done pulse |
| convResult | input | 12 | Converter result word, valid with `convDone` |
| busy | output | 1 | Conversion or burst run in progress |
| resValid | output | 1 | One-cycle pulse when `resData` is updated |
| resData | output | 19 | Result or accumulated value |
| cmdState | output | 8 | Command register contents |

## Verification
The embedded assertions watch, on every cycle, the invariants that hold regardless of the scenario:
- a request only accompanies the busy state
- a stop write clears busy and request on the next cycle
- an immediate write with the converter disabled is stored as stop
- reserved modes never request
- the run counter stays still while a conversion is in flight
- scaled single-ended and narrow results stay within their magnitude

Only the bench's scenarios show that the arithmetic values are right: the sums, sign extension and scaling. They also show which trigger source fires and that a burst issues exactly the programmed number of requests. The remaining scenario-only behaviours are the discarded partial sum after a mode change, and that freeRun keeps producing results until stopped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [2:0] MD_SNG8  = 3'd0;
  localparam logic [2:0] MD_SNG12 = 3'd1;
  localparam logic [2:0] MD_SER   = 3'd2;
  localparam logic [2:0] MD_SERSC = 3'd3;
  localparam logic [2:0] MD_BST   = 3'd4;
  localparam logic [2:0] MD_BSTSC = 3'd5;

  localparam logic [2:0] ST_STOP = 3'd0;
  localparam logic [2:0] ST_IMM  = 3'd1;
  localparam logic [2:0] ST_POS  = 3'd2;
  localparam logic [2:0] ST_NEG  = 3'd3;
  localparam logic [2:0] ST_EVT  = 3'd4;

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_POS = 2'd1;
  localparam logic [1:0] ADDR_NEG = 2'd2;
  localparam logic [1:0] ADDR_CNT = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic       take;    // a converter result is accepted this cycle
    logic       last;    // the accepted result closes the run
    logic       clr;     // discard the partial sum
    logic       diff;    // signed interpretation
    logic       narrow;  // keep only the top 8 bits
    logic       scale;   // shift the closed sum right
    logic [2:0] shift;   // shift amount (exponent)
  } strobe_t;

  function automatic logic isAcc(input logic [2:0] m);
    return (m >= MD_SER) && (m <= MD_BSTSC);
  endfunction

  function automatic logic isSingle(input logic [2:0] m);
    return m <= MD_SNG12;
  endfunction

  function automatic logic isBurst(input logic [2:0] m);
    return (m == MD_BST) || (m == MD_BSTSC);
  endfunction

  function automatic logic isScale(input logic [2:0] m);
    return (m == MD_SERSC) || (m == MD_BSTSC);
  endfunction

  function automatic logic isLegal(input logic [2:0] m);
    return m <= MD_BSTSC;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_W    = 8,
  parameter int MAX_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             freeRun,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic             evtTrig,
  input  logic             convDone,
  output logic             convReq,
  output logic             busy,
  output logic [7:0]       cmdState,
  output logic             convDiff,
  output logic [SEL_W-1:0] convPos,
  output logic [SEL_W-1:0] convNeg,
  output strobe_t          stb
);

  localparam int CNT_W = MAX_LOG2 + 1;

  logic [7:0]       cmdQ;
  logic [SEL_W-1:0] posQ, negQ;
  logic [2:0]       log2Q;
  logic             busyQ, reqQ;
  logic [CNT_W-1:0] sampCnt;

  logic             busyN, reqN;
  logic [CNT_W-1:0] cntN;

  logic cmdWr, posWr, negWr, cntWr;
  logic [2:0] modeQ, startQ, wrMode, wrStart;
  logic clrAcc, trigger, take, lastHit, runDone, immRestart;
  logic [CNT_W-1:0] nSamp;

  assign cmdWr   = regWrEn && (regAddr == ADDR_CMD);
  assign posWr   = regWrEn && (regAddr == ADDR_POS);
  assign negWr   = regWrEn && (regAddr == ADDR_NEG);
  assign cntWr   = regWrEn && (regAddr == ADDR_CNT);

  assign modeQ   = cmdQ[6:4];
  assign startQ  = cmdQ[2:0];
  assign wrMode  = regWrData[6:4];
  assign wrStart = regWrData[2:0];

  // abort on stop, drop the partial sum on accumulating -> single
  assign clrAcc = cmdWr && ((wrStart == ST_STOP) || (isAcc(modeQ) && isSingle(wrMode)));

  assign trigger = enable && !busyQ && (
      (cmdWr && (wrStart == ST_IMM) && isLegal(wrMode)) ||
      (!cmdWr && isLegal(modeQ) && (
          (posWr   && (startQ == ST_POS)) ||
          (negWr   && (startQ == ST_NEG)) ||
          (evtTrig && (startQ == ST_EVT)))));

  assign nSamp      = CNT_W'(1) << log2Q;
  assign take       = convDone && busyQ && !clrAcc;
  assign lastHit    = isSingle(modeQ) || ((sampCnt + CNT_W'(1)) == nSamp);
  assign runDone    = take && (lastHit || !isBurst(modeQ));
  assign immRestart = (startQ == ST_IMM) && freeRun && enable;

  always_comb begin
    busyN = busyQ;
    reqN  = 1'b0;
    cntN  = sampCnt;
    if (clrAcc) begin
      busyN = 1'b0;
      cntN  = '0;
    end else if (take) begin
      cntN = lastHit ? '0 : sampCnt + CNT_W'(1);
      if (!runDone)       reqN  = 1'b1;
      else if (immRestart) reqN = 1'b1;
      else                busyN = 1'b0;
    end
    if (trigger) begin
      busyN = 1'b1;
      reqN  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      posQ    <= '0;
      negQ    <= '0;
      log2Q   <= '0;
      busyQ   <= 1'b0;
      reqQ    <= 1'b0;
      sampCnt <= '0;
    end else begin
      busyQ   <= busyN;
      reqQ    <= reqN;
      sampCnt <= cntN;
      if (cmdWr)
        cmdQ <= {regWrData[7:4], 1'b0,
                 ((wrStart == ST_IMM) && !enable) ? ST_STOP : wrStart};
      else if (runDone && (startQ == ST_IMM) && !immRestart)
        cmdQ[2:0] <= ST_STOP;
      if (posWr) posQ <= regWrData[SEL_W-1:0];
      if (negWr) negQ <= regWrData[SEL_W-1:0];
      if (cntWr && (regWrData <= 8'(MAX_LOG2))) log2Q <= regWrData[2:0];
    end
  end

  always_comb begin
    stb.take   = take;
    stb.last   = take && lastHit;
    stb.clr    = clrAcc;
    stb.diff   = cmdQ[7];
    stb.narrow = (modeQ == MD_SNG8);
    stb.scale  = isScale(modeQ);
    stb.shift  = log2Q;
  end

  assign convReq  = reqQ;
  assign busy     = busyQ;
  assign cmdState = cmdQ;
  assign convDiff = cmdQ[7];
  assign convPos  = posQ;
  assign convNeg  = negQ;

  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> busyQ);

  // R9
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (wrStart == ST_STOP)) |=> (!busyQ && !reqQ));

  // R11
  imm_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (wrStart == ST_IMM) && !enable) |=> (cmdQ[2:0] == ST_STOP));

  // R13
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !isLegal(wrMode) && !busyQ) |=> !reqQ);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !convDone && !cmdWr) |=> $stable(sampCnt));

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int ACC_W = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [RES_W-1:0] convResult,
  output logic             resValid,
  output logic [ACC_W-1:0] resData
);

  localparam int NAR_W = 8;

  logic [ACC_W-1:0] acc, ext, sum, shaped;
  logic [NAR_W-1:0] raw8;
  logic             scaledQ, diffQ, narrowQ;

  assign raw8 = convResult[RES_W-1 -: NAR_W];

  always_comb begin
    if (stb.narrow)
      ext = stb.diff ? {{(ACC_W-NAR_W){raw8[NAR_W-1]}}, raw8}
                     : {{(ACC_W-NAR_W){1'b0}}, raw8};
    else
      ext = stb.diff ? {{(ACC_W-RES_W){convResult[RES_W-1]}}, convResult}
                     : {{(ACC_W-RES_W){1'b0}}, convResult};
    sum = acc + ext;
    if (!stb.scale)    shaped = sum;
    else if (stb.diff) shaped = ACC_W'($signed(sum) >>> stb.shift);
    else               shaped = sum >> stb.shift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      resData  <= '0;
      resValid <= 1'b0;
      scaledQ  <= 1'b0;
      diffQ    <= 1'b0;
      narrowQ  <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (stb.clr) begin
        acc <= '0;
      end else if (stb.take) begin
        acc <= stb.last ? '0 : sum;
        if (stb.last) begin
          resData  <= shaped;
          resValid <= 1'b1;
          scaledQ  <= stb.scale;
          diffQ    <= stb.diff;
          narrowQ  <= stb.narrow;
        end
      end
    end
  end

  // R6
  scaled_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && scaledQ && !diffQ) |-> (resData < (ACC_W'(1) << RES_W)));

  // R3
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && narrowQ && !diffQ) |-> (resData < ACC_W'(256)));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int SEL_W    = 8,
  parameter int MAX_LOG2 = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    freeRun,
  input  logic                    regWrEn,
  input  logic [1:0]              regAddr,
  input  logic [7:0]              regWrData,
  input  logic                    evtTrig,
  output logic                    convReq,
  output logic                    convDiff,
  output logic [SEL_W-1:0]        convPos,
  output logic [SEL_W-1:0]        convNeg,
  input  logic                    convDone,
  input  logic [RES_W-1:0]        convResult,
  output logic                    busy,
  output logic                    resValid,
  output logic [RES_W+MAX_LOG2:0] resData,
  output logic [7:0]              cmdState
);

  localparam int ACC_W = RES_W + MAX_LOG2 + 1;

  strobe_t stb;

  adc_seq_ctrl #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .evtTrig(evtTrig), .convDone(convDone), .convReq(convReq),
    .busy(busy), .cmdState(cmdState), .convDiff(convDiff),
    .convPos(convPos), .convNeg(convNeg), .stb(stb)
  );

  adc_seq_dpath #(.RES_W(RES_W), .ACC_W(ACC_W)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .convResult(convResult),
    .resValid(resValid), .resData(resData)
  );

endmodule

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [2:0]  lg;
    logic [6:0]  trig;
    logic [11:0] val;
    logic [18:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h11, 3'd2, 7'd1, 12'hABC, 19'h00ABC},
    '{8'h01, 3'd0, 7'd1, 12'hABC, 19'h000AB},
    '{8'h81, 3'd0, 7'd1, 12'h8F0, 19'h7FF8F},
    '{8'h91, 3'd0, 7'd1, 12'hFFE, 19'h7FFFE},
    '{8'h41, 3'd2, 7'd1, 12'h100, 19'h00400},
    '{8'h51, 3'd3, 7'd1, 12'h7FF, 19'h007FF},
    '{8'h41, 3'd6, 7'd1, 12'hFFF, 19'h3FFC0},
    '{8'hC1, 3'd1, 7'd1, 12'h800, 19'h7F000},
    '{8'hD1, 3'd2, 7'd1, 12'hF00, 19'h7FF00},
    '{8'h41, 3'd0, 7'd1, 12'h123, 19'h00123},
    '{8'h21, 3'd1, 7'd2, 12'h050, 19'h000A0},
    '{8'h31, 3'd2, 7'd4, 12'h333, 19'h00333}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        freeRun = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        evtTrig = 1'b0;
  logic        convReq, convDiff, busy, resValid;
  logic [7:0]  convPos, convNeg, cmdState;
  logic        convDone = 1'b0;
  logic [11:0] convResult = '0;
  logic [18:0] resData;

  logic [11:0] curVal = '0;
  int reqCount = 0;
  int delay = 0;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq uut (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .evtTrig(evtTrig), .convReq(convReq), .convDiff(convDiff),
    .convPos(convPos), .convNeg(convNeg), .convDone(convDone),
    .convResult(convResult), .busy(busy), .resValid(resValid),
    .resData(resData), .cmdState(cmdState)
  );

  // converter model: done pulse LAT negedges after a request
  always @(negedge clk) begin
    convDone = 1'b0;
    if (convReq) begin
      reqCount++;
      delay = LAT;
    end else if (delay > 0) begin
      delay--;
      if (delay == 0) begin
        convDone   = 1'b1;
        convResult = curVal;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle(output logic got, output logic [18:0] val);
    got = 1'b0; val = '0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (resValid) begin got = 1'b1; val = resData; end
      if (!busy && !convReq) break;
    end
  endtask

  task automatic countValid(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (resValid) cnt++;
    end
  endtask

  task automatic pulseEvt();
    @(negedge clk); evtTrig = 1'b1;
    @(negedge clk); evtTrig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic got;
    logic [18:0] val;
    int rc, nv;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd reset", cmdState, 8'h00);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 req reset", convReq, 1'b0);
    chk("R1 valid reset", resValid, 1'b0);
    chk("R1 data reset", resData, 19'h0);

    // vector table: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = (VECS[v].cmd[6:4] <= 3'd1) ? "R3" :
            (VECS[v].cmd[6:4] <= 3'd3) ? "R4" : "R5";
      if (VECS[v].cmd[4] && VECS[v].cmd[6:4] != 3'd1) tag = {tag, " R6"};
      if (VECS[v].cmd[7]) tag = {tag, " R2"};
      curVal = VECS[v].val;
      wrReg(2'd3, {5'b0, VECS[v].lg});
      for (int t = 0; t < int'(VECS[v].trig); t++) begin
        wrReg(2'd0, VECS[v].cmd);
        waitIdle(got, val);
        if (t < int'(VECS[v].trig) - 1)
          chk({tag, " early valid"}, got, 1'b0);
      end
      chk({tag, " valid"}, got, 1'b1);
      chk({tag, " value"}, val, VECS[v].exp);
      chk("R10 self clear", cmdState, VECS[v].cmd & 8'hF8);
    end

    // R14: exponent 7 rejected, stays 2 -> burst of 4
    wrReg(2'd3, 8'd7);
    curVal = 12'd1;
    wrReg(2'd0, 8'h41);
    waitIdle(got, val);
    chk("R14 exponent kept", val, 19'd4);

    // R11: immediate with enable low stored as stop
    enable = 1'b0;
    rc = reqCount;
    wrReg(2'd0, 8'h11);
    repeat (10) @(negedge clk);
    chk("R11 stored stop", cmdState, 8'h10);
    chk("R11 no request", reqCount, rc);
    enable = 1'b1;

    // R13: reserved mode and reserved start
    rc = reqCount;
    wrReg(2'd0, 8'h61);
    repeat (10) @(negedge clk);
    chk("R13 reserved mode", reqCount, rc);
    wrReg(2'd0, 8'h15);
    repeat (10) @(negedge clk);
    chk("R13 reserved start", reqCount, rc);
    chk("R13 not busy", busy, 1'b0);

    // R8: positive-select write trigger
    wrReg(2'd0, 8'h12);
    curVal = 12'h321;
    rc = reqCount;
    wrReg(2'd2, 8'h05);
    repeat (10) @(negedge clk);
    chk("R8 neg write ignored", reqCount, rc);
    wrReg(2'd1, 8'h0A);
    waitIdle(got, val);
    chk("R8 pos trigger", val, 19'h321);
    chk("R8 pos select out", convPos, 8'h0A);
    chk("R8 neg select out", convNeg, 8'h05);
    chk("R8 start kept", cmdState, 8'h12);
    // negative-select write trigger
    wrReg(2'd0, 8'h13);
    curVal = 12'h0F0;
    rc = reqCount;
    wrReg(2'd1, 8'h03);
    repeat (10) @(negedge clk);
    chk("R8 pos write ignored", reqCount, rc);
    wrReg(2'd2, 8'h06);
    waitIdle(got, val);
    chk("R8 neg trigger", val, 19'h0F0);
    // event trigger
    wrReg(2'd0, 8'h14);
    curVal = 12'h777;
    pulseEvt();
    waitIdle(got, val);
    chk("R8 event trigger", val, 19'h777);
    chk("R2 diff pin low", convDiff, 1'b0);
    wrReg(2'd0, 8'h90);
    chk("R2 diff pin high", convDiff, 1'b1);

    // R12: second event during a burst of 4 is ignored
    wrReg(2'd3, 8'd2);
    wrReg(2'd0, 8'h44);
    curVal = 12'd5;
    rc = reqCount;
    pulseEvt();
    repeat (3) @(negedge clk);
    pulseEvt();
    waitIdle(got, val);
    chk("R12 burst sum", val, 19'd20);
    chk("R12 request count", reqCount - rc, 4);

    // R9: stop aborts a long burst
    wrReg(2'd3, 8'd6);
    wrReg(2'd0, 8'h41);
    repeat (20) @(negedge clk);
    wrReg(2'd0, 8'h40);
    chk("R9 busy cleared", busy, 1'b0);
    chk("R9 req cleared", convReq, 1'b0);
    rc = reqCount;
    countValid(60, nv);
    chk("R9 no result", nv, 0);
    chk("R9 no request", reqCount, rc);

    // R7: accumulating -> single discards the partial sum
    wrReg(2'd3, 8'd2);
    curVal = 12'd100;
    for (int t = 0; t < 2; t++) begin
      wrReg(2'd0, 8'h21);
      waitIdle(got, val);
    end
    wrReg(2'd0, 8'h12);
    curVal = 12'd7;
    for (int t = 0; t < 4; t++) begin
      wrReg(2'd0, 8'h21);
      waitIdle(got, val);
      if (t < 3) chk("R7 no early valid", got, 1'b0);
    end
    chk("R7 fresh sum", val, 19'd28);

    // R10: free-running restart until stop
    freeRun = 1'b1;
    curVal = 12'h042;
    wrReg(2'd0, 8'h11);
    countValid(40, nv);
    chk("R10 free-run results", nv >= 3, 1'b1);
    chk("R10 start held", cmdState, 8'h11);
    wrReg(2'd0, 8'h10);
    countValid(20, nv);
    chk("R10 stopped", nv, 0);
    chk("R10 idle", busy, 1'b0);
    freeRun = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule